// File: doc/BRIEF.md
# Two-Bank Graphics DRAM Command Decoder and Bank Tracker

This block sits on the command side of a model of a two-bank synchronous graphics DRAM. On every rising clock edge it samples the clock-enable, chip-select, row strobe, column strobe, write-enable and special-function pins, along with the bank select and the address. From them it works out which operation was issued. It tracks whether each bank is idle or has a row open, and for an open bank it keeps the row address. The special-function pin splits several strobe codes into an ordinary form and a special form. The clock-enable history separates normal cycles from clock suspend, power-down and self-refresh entry.

The decoded operation leaves the block as a registered one-hot vector. Beside it are the target bank, the auto-precharge flag, and two qualifiers: one for block write and one for masked write on activate. An illegal operation raises an error flag and does not change any bank state. Examples of illegal operations are a column access to an idle bank and a mode set with a row open.

Two inputs connect the block to a separate burst engine. One tells the block that a burst is in progress. The other is a one-cycle pulse that ends the current burst and triggers any pending auto-precharge.

Top module: `sgcmd_tracker`

## Requirements
- R1: All outputs are registered and reflect the pins sampled at the previous rising edge. After reset the command vector is all zero, both banks are idle and no error is flagged. After that, exactly one command bit is set each cycle. The bit positions are: 0 deselect, 1 no-op, 2 activate, 3 precharge one bank, 4 precharge all, 5 read, 6 write, 7 block write, 8 mode set, 9 special mode set, 10 auto refresh, 11 self-refresh entry, 12 burst stop, 13 clock suspend, 14 power-down, 15 hold, 16 reserved code.
- R2: With clock-enable high in this cycle and the previous one, chip-select high decodes as deselect (bit 0) and changes no bank state.
- R3: With chip-select low, all three strobes high decodes as no-op (bit 1), whatever the special-function pin is.
- R4: Row strobe low with column strobe and write-enable high is activate. The addressed bank becomes active and stores the full address as its open row. The masked-write qualifier repeats the special-function pin.
- R5: Row strobe low, column strobe high, write-enable low and special-function low is a precharge. Address bit 8 low idles only the selected bank and reports bit 3. Address bit 8 high idles both banks and reports bit 4.
- R6: Row strobe high with column strobe low is a column command. Write-enable high is a read. Write-enable low is a write, or a block write when special-function is high; the block qualifier is set for block write. Address bit 8 sets the auto-precharge flag. A column command aimed at an idle bank is illegal.
- R7: A legal column command with auto-precharge marks its bank. The bank stays active until the burst-done input is sampled high, and is idle after that edge.
- R8: All three strobes low with special-function low is mode set, which is illegal while any bank is active. With special-function high it is special mode set, which is legal whether or not a bank is active.
- R9: Row and column strobes low, write-enable high and special-function low is a refresh. With clock-enable high in both cycles it is auto refresh. If clock-enable was high and is now low, it is self-refresh entry. Both are illegal while any bank is active.
- R10: Row and column strobes high, write-enable low and special-function low is burst stop. It is illegal unless the burst-busy input is high.
- R11: A falling clock-enable with any other pins gives clock suspend (bit 13) when a burst is busy or a bank is active, and power-down (bit 14) otherwise. Every cycle whose previous clock-enable sample was low reports hold (bit 15) and changes no bank state.
- R12: An illegal command sets the error output for that cycle only and leaves bank states and open rows unchanged. Activating a bank that is already active is illegal. The unused strobe/special-function codes decode as reserved (bit 16) and are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| bank_sel | input | 1 | Bank select |
| addr | input | 11 | Row address or command qualifiers |
| burst_busy | input | 1 | A burst is in progress |
| burst_done | input | 1 | Current burst completes this cycle |
| cmd_onehot | output | 17 | Decoded command, one bit per operation |
| cmd_bank | output | 1 | Bank the command was aimed at |
| cmd_autopre | output | 1 | Column command carries auto-precharge |
| cmd_block | output | 1 | Write is a block write |
| cmd_mask | output | 1 | Activate enables masked write |
| cmd_illegal | output | 1 | Command was illegal in the current state |
| bank_active | output | 2 | Per-bank row-open flags |
| open_rows | output | 22 | Open row per bank, bank 0 in the low bits |

## Verification
The assertions assume that burst_busy comes from a burst engine that follows the decoded commands. This means burst stop and clock suspend are checked against the value of burst_busy sampled in the same cycle as the command. They also assume that burst_done pulses only to end a burst. The bench drives burst_busy and burst_done by hand, and only around the commands they belong to. All pins change on the falling edge, so each command is sampled at exactly one rising edge and no setup window is ever ambiguous.

// File: rtl/sgcmd_pkg.sv
// Shared command encoding for the graphics DRAM command tracker.
// Enum value equals the bit position in the one-hot command output.
package sgcmd_pkg;
    localparam int NCMD = 17;

    typedef enum logic [4:0] {
        CMD_DESEL  = 5'd0,
        CMD_NOP    = 5'd1,
        CMD_ACT    = 5'd2,
        CMD_PRE    = 5'd3,
        CMD_PREALL = 5'd4,
        CMD_READ   = 5'd5,
        CMD_WRITE  = 5'd6,
        CMD_BWRITE = 5'd7,
        CMD_MRS    = 5'd8,
        CMD_SMRS   = 5'd9,
        CMD_AREF   = 5'd10,
        CMD_SREF   = 5'd11,
        CMD_BSTOP  = 5'd12,
        CMD_SUSP   = 5'd13,
        CMD_PDOWN  = 5'd14,
        CMD_HOLD   = 5'd15,
        CMD_RSVD   = 5'd16
    } cmd_e;
endpackage

// File: rtl/sgcmd_decode.sv
// Combinational pin decoder.
// Maps the sampled strobes, special-function pin and clock-enable history
// to one command code. Assumes cke_prev is the clock-enable sampled at the
// previous edge. It does not judge legality.
module sgcmd_decode
    import sgcmd_pkg::*;
(
    input  logic cke,
    input  logic cke_prev,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic dsf,
    input  logic ap_bit,
    input  logic any_active,
    input  logic burst_busy,
    output cmd_e cmd
);
    logic refresh_code;

    // Refresh strobe pattern, shared by auto refresh and self-refresh entry.
    assign refresh_code = !cs_n && !ras_n && !cas_n && we_n && !dsf;

    // Select the command from clock-enable history, then the strobe code.
    always_comb begin
        cmd = CMD_RSVD;
        if (!cke_prev) begin
            cmd = CMD_HOLD;
        end else if (!cke) begin
            if (refresh_code)
                cmd = CMD_SREF;
            else if (burst_busy || any_active)
                cmd = CMD_SUSP;
            else
                cmd = CMD_PDOWN;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            casez ({ras_n, cas_n, we_n, dsf})
                4'b111?: cmd = CMD_NOP;
                4'b011?: cmd = CMD_ACT;
                4'b0100: cmd = ap_bit ? CMD_PREALL : CMD_PRE;
                4'b1000: cmd = CMD_WRITE;
                4'b1001: cmd = CMD_BWRITE;
                4'b1010: cmd = CMD_READ;
                4'b0000: cmd = CMD_MRS;
                4'b0001: cmd = CMD_SMRS;
                4'b0010: cmd = CMD_AREF;
                4'b1100: cmd = CMD_BSTOP;
                default: cmd = CMD_RSVD;
            endcase
        end
    end
endmodule

// File: rtl/sgcmd_rules.sv
// Legality checker.
// Judges a decoded command against the current bank states and the
// burst-busy input. Assumes bank_active holds the state before this command.
module sgcmd_rules
    import sgcmd_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int BANK_W = 1
) (
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [NBANK-1:0]  bank_active,
    input  logic              burst_busy,
    output logic              illegal
);
    logic tgt_active;
    logic any_active;

    assign tgt_active = bank_active[bank_sel];
    assign any_active = |bank_active;

    // Flag commands that the current state does not allow.
    always_comb begin
        case (cmd)
            CMD_ACT:                        illegal = tgt_active;
            CMD_READ, CMD_WRITE, CMD_BWRITE: illegal = !tgt_active;
            CMD_MRS, CMD_AREF, CMD_SREF:    illegal = any_active;
            CMD_BSTOP:                      illegal = !burst_busy;
            CMD_RSVD:                       illegal = 1'b1;
            default:                        illegal = 1'b0;
        endcase
    end
endmodule

// File: rtl/sgcmd_bank.sv
// One bank's state: idle or active, the open row, and a pending
// auto-precharge mark. Assumes the caller only raises strobes for
// legal commands. Precharge wins over activate. A new auto-precharge
// mark wins over burst_done in the same cycle.
module sgcmd_bank #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             set_ap,
    input  logic             burst_done,
    input  logic [ROW_W-1:0] row_in,
    output logic             active,
    output logic [ROW_W-1:0] row
);
    logic ap_pend;

    // Update the row-open flag, the stored row and the auto-precharge mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            row     <= '0;
            ap_pend <= 1'b0;
        end else if (do_pre) begin
            active  <= 1'b0;
            ap_pend <= 1'b0;
        end else if (do_act) begin
            active  <= 1'b1;
            row     <= row_in;
        end else if (set_ap) begin
            ap_pend <= 1'b1;
        end else if (burst_done && ap_pend) begin
            active  <= 1'b0;
            ap_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sgcmd_tracker.sv
// Top level: command decoder and bank tracker for a two-bank graphics DRAM model.
// Samples the pins each rising edge and registers the decoded command,
// its qualifiers and an error flag. Keeps per-bank state.
// Assumes burst_busy and burst_done come from a separate burst engine.
module sgcmd_tracker
    import sgcmd_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int ADDR_W = 11,
    parameter int AP_BIT = 8,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int ROW_W  = ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   dsf,
    input  logic [BANK_W-1:0]      bank_sel,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   burst_busy,
    input  logic                   burst_done,
    output logic [NCMD-1:0]        cmd_onehot,
    output logic [BANK_W-1:0]      cmd_bank,
    output logic                   cmd_autopre,
    output logic                   cmd_block,
    output logic                   cmd_mask,
    output logic                   cmd_illegal,
    output logic [NBANK-1:0]       bank_active,
    output logic [NBANK*ROW_W-1:0] open_rows
);
    logic cke_prev;
    cmd_e cmd;
    logic illegal;
    logic is_col;

    // Remember clock-enable from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_prev <= 1'b1;
        else        cke_prev <= cke;
    end

    sgcmd_decode u_decode (
        .cke        (cke),
        .cke_prev   (cke_prev),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .dsf        (dsf),
        .ap_bit     (addr[AP_BIT]),
        .any_active (|bank_active),
        .burst_busy (burst_busy),
        .cmd        (cmd)
    );

    sgcmd_rules #(.NBANK(NBANK), .BANK_W(BANK_W)) u_rules (
        .cmd         (cmd),
        .bank_sel    (bank_sel),
        .bank_active (bank_active),
        .burst_busy  (burst_busy),
        .illegal     (illegal)
    );

    assign is_col = (cmd == CMD_READ) || (cmd == CMD_WRITE) || (cmd == CMD_BWRITE);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel;
        assign sel = (bank_sel == BANK_W'(b));

        sgcmd_bank #(.ROW_W(ROW_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .do_act     (!illegal && cmd == CMD_ACT && sel),
            .do_pre     ((cmd == CMD_PRE && sel) || cmd == CMD_PREALL),
            .set_ap     (!illegal && is_col && addr[AP_BIT] && sel),
            .burst_done (burst_done),
            .row_in     (addr),
            .active     (bank_active[b]),
            .row        (open_rows[b*ROW_W +: ROW_W])
        );
    end

    // Register the decoded command and its qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_onehot  <= '0;
            cmd_bank    <= '0;
            cmd_autopre <= 1'b0;
            cmd_block   <= 1'b0;
            cmd_mask    <= 1'b0;
            cmd_illegal <= 1'b0;
        end else begin
            cmd_onehot  <= NCMD'(1) << cmd;
            cmd_bank    <= bank_sel;
            cmd_autopre <= is_col && addr[AP_BIT];
            cmd_block   <= (cmd == CMD_BWRITE);
            cmd_mask    <= (cmd == CMD_ACT) && dsf;
            cmd_illegal <= illegal;
        end
    end
endmodule

// File: rtl/sgcmd_tracker_chk.sv
// Property checker for sgcmd_tracker, attached with bind.
// Observes ports only and keeps a one-cycle copy of the bank flags.
module sgcmd_tracker_chk
    import sgcmd_pkg::*;
#(
    parameter int NBANK  = 2,
    parameter int BANK_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              burst_busy,
    input logic [NCMD-1:0]   cmd_onehot,
    input logic [BANK_W-1:0] cmd_bank,
    input logic              cmd_illegal,
    input logic [NBANK-1:0]  bank_active
);
    logic [NBANK-1:0] bank_prev;
    logic             busy_prev;

    // Keep the bank flags and burst-busy from one cycle back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_prev <= '0;
            busy_prev <= 1'b0;
        end else begin
            bank_prev <= bank_active;
            busy_prev <= burst_busy;
        end
    end

    AST_ONEHOT_CMD: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cmd_onehot)); // R1
    AST_DESEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> (bank_active == bank_prev)); // R2
    AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) cmd_illegal |-> (bank_active == bank_prev)); // R12
    AST_ACT_BUSY_BANK: assert property (@(posedge clk) disable iff (!rst_n) (cmd_onehot[CMD_ACT] && bank_prev[cmd_bank]) |-> cmd_illegal); // R12
    AST_COL_IDLE_BANK: assert property (@(posedge clk) disable iff (!rst_n) (cmd_onehot[CMD_READ] && !bank_prev[cmd_bank]) |-> cmd_illegal); // R6
    AST_MRS_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n) (cmd_onehot[CMD_MRS] && (|bank_prev)) |-> cmd_illegal); // R8
    AST_BSTOP_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n) (cmd_onehot[CMD_BSTOP] && !busy_prev) |-> cmd_illegal); // R10
    AST_PREALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_onehot[CMD_PREALL] |-> (bank_active == '0)); // R5
    AST_PDOWN_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n) cmd_onehot[CMD_PDOWN] |-> !busy_prev); // R11
endmodule

bind sgcmd_tracker sgcmd_tracker_chk #(.NBANK(NBANK), .BANK_W(BANK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .burst_busy  (burst_busy),
    .cmd_onehot  (cmd_onehot),
    .cmd_bank    (cmd_bank),
    .cmd_illegal (cmd_illegal),
    .bank_active (bank_active)
);

// File: tb/sgcmd_tracker_bench.sv
`timescale 1ns/100ps
// Directed bench for sgcmd_tracker: one task per scenario, each checking its results.
module sgcmd_tracker_bench;
    localparam int B_DESEL = 0, B_NOP = 1, B_ACT = 2, B_PRE = 3, B_PREALL = 4;
    localparam int B_READ = 5, B_WRITE = 6, B_BWRITE = 7, B_MRS = 8, B_SMRS = 9;
    localparam int B_AREF = 10, B_SREF = 11, B_BSTOP = 12, B_SUSP = 13;
    localparam int B_PDOWN = 14, B_HOLD = 15, B_RSVD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
    logic bank_sel = 1'b0;
    logic [10:0] addr = '0;
    logic burst_busy = 1'b0, burst_done = 1'b0;
    logic [16:0] cmd_onehot;
    logic cmd_bank, cmd_autopre, cmd_block, cmd_mask, cmd_illegal;
    logic [1:0] bank_active;
    logic [21:0] open_rows;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sgcmd_tracker u_sgcmd_tracker (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dsf(dsf), .bank_sel(bank_sel), .addr(addr),
        .burst_busy(burst_busy), .burst_done(burst_done),
        .cmd_onehot(cmd_onehot), .cmd_bank(cmd_bank), .cmd_autopre(cmd_autopre),
        .cmd_block(cmd_block), .cmd_mask(cmd_mask), .cmd_illegal(cmd_illegal),
        .bank_active(bank_active), .open_rows(open_rows)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one command on the falling edge; return just after the sampling edge.
    task automatic issue(input logic k, input logic cs, input logic r, input logic c,
                         input logic w, input logic d, input logic b, input logic [10:0] a);
        @(negedge clk);
        cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; dsf = d; bank_sel = b; addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();
        issue(1, 0, 1, 1, 1, 0, 0, 11'h0);
    endtask

    task automatic t_reset();
        chk("R1 reset cmd", int'(cmd_onehot), 0);
        chk("R1 reset banks", int'(bank_active), 0);
        chk("R1 reset error", int'(cmd_illegal), 0);
    endtask

    task automatic t_desel();
        issue(1, 1, 0, 1, 1, 0, 0, 11'h123);
        chk("R2 deselect bit", int'(cmd_onehot), 1 << B_DESEL);
        chk("R2 no activate", int'(bank_active), 0);
    endtask

    task automatic t_nop();
        issue(1, 0, 1, 1, 1, 1, 0, 11'h0);
        chk("R3 nop with dsf high", int'(cmd_onehot), 1 << B_NOP);
    endtask

    task automatic t_activate();
        issue(1, 0, 0, 1, 1, 1, 0, 11'h5A3);
        chk("R4 act bit", int'(cmd_onehot), 1 << B_ACT);
        chk("R4 mask qualifier", int'(cmd_mask), 1);
        chk("R4 bank0 open", int'(bank_active), 1);
        chk("R4 row0", int'(open_rows[10:0]), 'h5A3);
        issue(1, 0, 0, 1, 1, 0, 1, 11'h012);
        chk("R4 mask low", int'(cmd_mask), 0);
        chk("R4 both open", int'(bank_active), 3);
        chk("R4 row1", int'(open_rows[21:11]), 'h012);
        issue(1, 0, 0, 1, 1, 0, 0, 11'h111);
        chk("R12 act on active bank", int'(cmd_illegal), 1);
        chk("R12 row kept", int'(open_rows[10:0]), 'h5A3);
        nop();
        chk("R12 error one cycle", int'(cmd_illegal), 0);
    endtask

    task automatic t_column();
        issue(1, 0, 1, 0, 1, 0, 0, 11'h010);
        chk("R6 read bit", int'(cmd_onehot), 1 << B_READ);
        chk("R6 read legal", int'(cmd_illegal), 0);
        chk("R6 no autopre", int'(cmd_autopre), 0);
        issue(1, 0, 1, 0, 0, 1, 1, 11'h120);
        chk("R6 block write bit", int'(cmd_onehot), 1 << B_BWRITE);
        chk("R6 block qualifier", int'(cmd_block), 1);
        chk("R6 autopre flag", int'(cmd_autopre), 1);
        nop();
        chk("R7 bank1 open until done", int'(bank_active), 3);
        burst_done = 1'b1;
        nop();
        burst_done = 1'b0;
        chk("R7 bank1 idle after done", int'(bank_active), 1);
        issue(1, 0, 1, 0, 1, 0, 1, 11'h000);
        chk("R6 read idle bank", int'(cmd_illegal), 1);
        issue(1, 0, 1, 0, 0, 0, 0, 11'h004);
        chk("R6 write bit", int'(cmd_onehot), 1 << B_WRITE);
        chk("R6 write not block", int'(cmd_block), 0);
        chk("R6 write legal", int'(cmd_illegal), 0);
    endtask

    task automatic t_modereg();
        issue(1, 0, 0, 0, 0, 0, 0, 11'h020);
        chk("R8 mrs bit", int'(cmd_onehot), 1 << B_MRS);
        chk("R8 mrs with open row", int'(cmd_illegal), 1);
        issue(1, 0, 0, 0, 0, 1, 0, 11'h020);
        chk("R8 smrs bit", int'(cmd_onehot), 1 << B_SMRS);
        chk("R8 smrs legal", int'(cmd_illegal), 0);
    endtask

    task automatic t_bstop();
        issue(1, 0, 1, 1, 0, 0, 0, 11'h0);
        chk("R10 bstop bit", int'(cmd_onehot), 1 << B_BSTOP);
        chk("R10 bstop idle burst", int'(cmd_illegal), 1);
        burst_busy = 1'b1;
        issue(1, 0, 1, 1, 0, 0, 0, 11'h0);
        chk("R10 bstop in burst", int'(cmd_illegal), 0);
    endtask

    task automatic t_suspend();
        issue(0, 0, 1, 1, 1, 0, 0, 11'h0);
        chk("R11 suspend in burst", int'(cmd_onehot), 1 << B_SUSP);
        issue(0, 0, 1, 1, 1, 0, 0, 11'h0);
        chk("R11 hold low", int'(cmd_onehot), 1 << B_HOLD);
        issue(1, 0, 0, 1, 1, 0, 1, 11'h0);
        chk("R11 hold on exit", int'(cmd_onehot), 1 << B_HOLD);
        chk("R11 hold no activate", int'(bank_active), 1);
        burst_busy = 1'b0;
        nop();
        issue(0, 0, 1, 1, 1, 0, 0, 11'h0);
        chk("R11 suspend open row", int'(cmd_onehot), 1 << B_SUSP);
        issue(1, 1, 1, 1, 1, 0, 0, 11'h0);
        nop();
        chk("R1 normal again", int'(cmd_onehot), 1 << B_NOP);
    endtask

    task automatic t_precharge();
        issue(1, 0, 0, 0, 1, 0, 0, 11'h0);
        chk("R9 aref open row", int'(cmd_illegal), 1);
        chk("R9 aref bit", int'(cmd_onehot), 1 << B_AREF);
        issue(1, 0, 0, 1, 1, 0, 1, 11'h033);
        chk("R4 reopen bank1", int'(bank_active), 3);
        issue(1, 0, 0, 1, 0, 0, 0, 11'h000);
        chk("R5 single precharge bit", int'(cmd_onehot), 1 << B_PRE);
        chk("R5 bank0 idle only", int'(bank_active), 2);
        issue(1, 0, 0, 1, 0, 0, 0, 11'h100);
        chk("R5 precharge all bit", int'(cmd_onehot), 1 << B_PREALL);
        chk("R5 all idle", int'(bank_active), 0);
    endtask

    task automatic t_lowpower();
        issue(0, 0, 1, 1, 1, 0, 0, 11'h0);
        chk("R11 power-down bit", int'(cmd_onehot), 1 << B_PDOWN);
        issue(1, 1, 1, 1, 1, 0, 0, 11'h0);
        nop();
        issue(1, 0, 0, 0, 1, 0, 0, 11'h0);
        chk("R9 aref bit idle", int'(cmd_onehot), 1 << B_AREF);
        chk("R9 aref legal", int'(cmd_illegal), 0);
        issue(0, 0, 0, 0, 1, 0, 0, 11'h0);
        chk("R9 self-refresh entry", int'(cmd_onehot), 1 << B_SREF);
        chk("R9 sref legal", int'(cmd_illegal), 0);
        issue(0, 1, 1, 1, 1, 0, 0, 11'h0);
        issue(1, 1, 1, 1, 1, 0, 0, 11'h0);
        nop();
    endtask

    task automatic t_reserved();
        issue(1, 0, 0, 1, 0, 1, 0, 11'h0);
        chk("R12 reserved bit", int'(cmd_onehot), 1 << B_RSVD);
        chk("R12 reserved illegal", int'(cmd_illegal), 1);
        chk("R12 reserved no change", int'(bank_active), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_desel();
        t_nop();
        t_activate();
        t_column();
        t_modereg();
        t_bstop();
        t_suspend();
        t_precharge();
        t_lowpower();
        t_reserved();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule